// File: doc/BRIEF.md
# Instanced Attribute Index Unit

This unit turns a linear thread index into the element index used to fetch a vertex or instance attribute. A two-bit mode chooses the conversion for each request. The index can pass through unchanged. It can be reduced modulo a padded vertex count. It can be divided by a power of two. It can be divided by an arbitrary constant through a reciprocal multiplier. Each request carries its own mode, a shift amount, a 32-bit multiplier and a 3-bit extra-flags field. These values are captured together with the index when the request is accepted.

Requests enter through a valid/ready handshake and leave through another one. The unit can accept one request per clock. Every request takes the same number of cycles. When the consumer deasserts ready, the whole pipeline freezes. The result on the output then stays as it is until the consumer takes it. Stride arithmetic and memory access belong to the stage that follows this unit.

Top module: `attr_index_unit`

## Requirements
- R1: With mode code 0 (pass-through), out_index equals the accepted in_index.
- R2: With mode code 1 (modulo), out_index is in_index mod (F · 2^in_shift), where F = 2·in_xflags+1 for in_xflags 0..4. Any in_xflags value above 4 selects F = 9.
- R3: With mode code 2 (power-of-two divide), out_index is in_index shifted right by in_shift. in_xflags is ignored in this mode.
- R4: With mode code 3 (reciprocal divide), the unit multiplies in_index by the multiplier into a 64-bit product and keeps its upper 32 bits. The index is not shifted before the multiply. The kept value is then shifted right by in_shift.
- R5: In reciprocal divide mode, bit 31 of in_mult is taken as 1 even when it is supplied as 0.
- R6: In reciprocal divide mode, in_xflags equal to 1 adds the round-down correction: the kept value is the upper half of (in_index+1)·multiplier, with no overflow at in_index = 0xFFFFFFFF. Every other in_xflags value applies no correction.
- R7: A request accepted on a clock edge shows on out_valid/out_index after the third rising edge, counting the accepting edge. This holds when out_ready stays high.
- R8: While out_valid is high and out_ready is low, out_valid and out_index hold their values and in_ready is low.
- R9: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R10: With out_ready held high, requests presented on consecutive cycles are all accepted back to back and come out in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 2 | 0 pass-through, 1 modulo, 2 shift divide, 3 reciprocal divide |
| in_shift | input | 5 | Shift amount |
| in_xflags | input | 3 | Odd-factor select or round-down enable |
| in_mult | input | 32 | Reciprocal multiplier (bit 31 implied) |
| in_index | input | 32 | Linear thread index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | 32 | Attribute element index |

## Verification
Two events can happen on the same edge: the consumer releases a held result, and a new request is accepted. In the stall scenario, three requests fill the pipeline while out_ready is low. The bench then checks over several cycles that the result is frozen and that in_ready is low. Next it raises out_ready in the same cycle that a fourth request is presented. The pass is judged by comparing every delivered result, in order, against a queue of expected values. Nothing may be lost, duplicated or reordered across that edge.

// File: rtl/aidx_pkg.sv
package aidx_pkg;
  localparam logic [1:0] MODE_PASS  = 2'd0;
  localparam logic [1:0] MODE_MOD   = 2'd1;
  localparam logic [1:0] MODE_SHR   = 2'd2;
  localparam logic [1:0] MODE_RECIP = 2'd3;
  localparam int XF_W  = 3;
  localparam int REM_W = 4;
endpackage

// File: rtl/aidx_odd_rem.sv
module aidx_odd_rem #(
  parameter int W = 32
) (
  input  logic [W-1:0]               val,
  input  logic [aidx_pkg::XF_W-1:0]  sel,
  output logic [aidx_pkg::REM_W-1:0] rem
);
  import aidx_pkg::*;

  always_comb begin
    case (sel)
      3'd0:    rem = '0;
      3'd1:    rem = REM_W'(val % W'(3));
      3'd2:    rem = REM_W'(val % W'(5));
      3'd3:    rem = REM_W'(val % W'(7));
      default: rem = REM_W'(val % W'(9));
    endcase
  end

  // R2: remainder is below the largest odd factor
  always_comb begin
    rem_range_chk: assert (rem < REM_W'(9));
  end
endmodule

// File: rtl/aidx_prod_stage.sv
module aidx_prod_stage #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       v_i,
  input  logic [1:0]                 mode_i,
  input  logic [SH_W-1:0]            shift_i,
  input  logic [aidx_pkg::XF_W-1:0]  xf_i,
  input  logic [W-1:0]               mult_i,
  input  logic [W-1:0]               idx_i,
  output logic                       v_q,
  output logic [1:0]                 mode_q,
  output logic [SH_W-1:0]            shift_q,
  output logic [W-1:0]               idx_q,
  output logic [aidx_pkg::REM_W-1:0] rem_q,
  output logic [W-1:0]               low_q,
  output logic [W-1:0]               hi_q
);
  import aidx_pkg::*;
  localparam int P_W = 2 * W;

  logic [W-1:0]     m_full;
  logic [P_W-1:0]   m_ext;
  logic [P_W-1:0]   prod;
  logic             corr;
  logic [W-1:0]     quo;
  logic [REM_W-1:0] rem;

  assign m_full = mult_i | (W'(1) << (W - 1));
  assign m_ext  = {{W{1'b0}}, m_full};
  assign corr   = (mode_i == MODE_RECIP) && (xf_i == XF_W'(1));
  assign prod   = {{W{1'b0}}, idx_i} * m_ext + (corr ? m_ext : '0);
  assign quo    = idx_i >> shift_i;

  aidx_odd_rem #(.W(W)) u_rem (
    .val(quo),
    .sel(xf_i),
    .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (en) begin
      v_q <= v_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      mode_q  <= mode_i;
      shift_q <= shift_i;
      idx_q   <= idx_i;
      rem_q   <= rem;
      low_q   <= idx_i & ~({W{1'b1}} << shift_i);
      hi_q    <= prod[P_W-1:W];
    end
  end

  // R5: with the top multiplier bit forced, the kept half lies in [idx/2, idx]
  magic_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q && mode_q == MODE_RECIP) |-> (hi_q <= idx_q && hi_q >= (idx_q >> 1)));
endmodule

// File: rtl/aidx_out_stage.sv
module aidx_out_stage #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       v_i,
  input  logic [1:0]                 mode_i,
  input  logic [SH_W-1:0]            shift_i,
  input  logic [W-1:0]               idx_i,
  input  logic [aidx_pkg::REM_W-1:0] rem_i,
  input  logic [W-1:0]               low_i,
  input  logic [W-1:0]               hi_i,
  output logic                       v_q,
  output logic [W-1:0]               res_q
);
  import aidx_pkg::*;

  logic [W-1:0] res;

  always_comb begin
    case (mode_i)
      MODE_MOD:   res = (W'(rem_i) << shift_i) | low_i;
      MODE_SHR:   res = idx_i >> shift_i;
      MODE_RECIP: res = hi_i >> shift_i;
      default:    res = idx_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (en) begin
      v_q <= v_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      res_q <= res;
    end
  end

  // R2: no mode produces an element index above the thread index
  result_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (en && v_i) |=> (res_q <= $past(idx_i)));
endmodule

// File: rtl/attr_index_unit.sv
module attr_index_unit #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_mode,
  input  logic [SH_W-1:0] in_shift,
  input  logic [2:0]      in_xflags,
  input  logic [W-1:0]    in_mult,
  input  logic [W-1:0]    in_index,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_index
);
  import aidx_pkg::*;

  logic             adv;
  logic             v1;
  logic [1:0]       mode1;
  logic [SH_W-1:0]  sh1;
  logic [XF_W-1:0]  xf1;
  logic [W-1:0]     mult1;
  logic [W-1:0]     idx1;
  logic             v2;
  logic [1:0]       mode2;
  logic [SH_W-1:0]  sh2;
  logic [W-1:0]     idx2;
  logic [REM_W-1:0] rem2;
  logic [W-1:0]     low2;
  logic [W-1:0]     hi2;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      mode1 <= in_mode;
      sh1   <= in_shift;
      xf1   <= in_xflags;
      mult1 <= in_mult;
      idx1  <= in_index;
    end
  end

  aidx_prod_stage #(.W(W), .SH_W(SH_W)) u_prod (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(v1), .mode_i(mode1), .shift_i(sh1), .xf_i(xf1),
    .mult_i(mult1), .idx_i(idx1),
    .v_q(v2), .mode_q(mode2), .shift_q(sh2), .idx_q(idx2),
    .rem_q(rem2), .low_q(low2), .hi_q(hi2)
  );

  aidx_out_stage #(.W(W), .SH_W(SH_W)) u_out (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(v2), .mode_i(mode2), .shift_i(sh2), .idx_i(idx2),
    .rem_i(rem2), .low_i(low2), .hi_i(hi2),
    .v_q(out_valid), .res_q(out_index)
  );

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);
endmodule

// File: tb/attr_index_unit_bench.sv
`timescale 1ns/1ps
module attr_index_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [2:0]  in_xflags = '0;
  logic [31:0] in_mult = '0;
  logic [31:0] in_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_index;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  attr_index_unit u_attr_index_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_shift(in_shift), .in_xflags(in_xflags),
    .in_mult(in_mult), .in_index(in_index), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] md, input logic [4:0] sh,
                                        input logic [2:0] xf, input logic [31:0] mu,
                                        input logic [31:0] ix);
    logic [63:0] d, p, m;
    case (md)
      2'd0: return ix;
      2'd1: begin
        d = (xf > 3'd4) ? 64'd9 : 64'(2 * xf + 1);
        d = d << sh;
        return 32'(64'(ix) % d);
      end
      2'd2: return ix >> sh;
      default: begin
        m = 64'(mu | 32'h8000_0000);
        p = 64'(ix) * m;
        if (xf == 3'd1) p = p + m;
        return p[63:32] >> sh;
      end
    endcase
  endfunction

  // scoreboard: every delivered result is compared in order
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected output", out_index, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_index == e, t, out_index, e);
      end
    end
  end

  task automatic send(input logic [1:0] md, input logic [4:0] sh, input logic [2:0] xf,
                      input logic [31:0] mu, input logic [31:0] ix,
                      input logic [31:0] ex, input string req);
    in_valid = 1'b1; in_mode = md; in_shift = sh; in_xflags = xf;
    in_mult = mu; in_index = ix;
    do @(negedge clk); while (!in_ready);
    exp_q.push_back(ex);
    tag_q.push_back(req);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic sendm(input logic [1:0] md, input logic [4:0] sh, input logic [2:0] xf,
                       input logic [31:0] mu, input logic [31:0] ix, input string req);
    send(md, sh, xf, mu, ix, model(md, sh, xf, mu, ix), req);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R10 drain", exp_q.size(), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
  endtask

  task automatic t_pass();
    send(2'd0, 5'd7, 3'd5, 32'h1234, 32'd0, 32'd0, "R1 zero");
    send(2'd0, 5'd3, 3'd1, 32'hFFFF, 32'hDEADBEEF, 32'hDEADBEEF, "R1 pattern");
    send(2'd0, 5'd31, 3'd7, 32'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 ones");
    drain();
  endtask

  task automatic t_modulo();
    send(2'd1, 5'd3, 3'd4, 32'd0, 32'd70, 32'd70, "R2 70 mod 72");
    send(2'd1, 5'd3, 3'd4, 32'd0, 32'd1000, 32'd1000 % 32'd72, "R2 1000 mod 72");
    send(2'd1, 5'd2, 3'd1, 32'd0, 32'd12345, 32'd12345 % 32'd12, "R2 mod 12");
    send(2'd1, 5'd4, 3'd2, 32'd0, 32'hFFFFFFFF, 32'hFFFFFFFF % 32'd80, "R2 mod 80");
    send(2'd1, 5'd0, 3'd3, 32'd0, 32'd100, 32'd2, "R2 mod 7");
    send(2'd1, 5'd5, 3'd0, 32'd0, 32'd1000, 32'd1000 % 32'd32, "R2 mod 32");
    send(2'd1, 5'd1, 3'd6, 32'd0, 32'd55, 32'd55 % 32'd18, "R2 clamp to 9");
    sendm(2'd1, 5'd31, 3'd4, 32'd0, 32'hFFFFFFFF, "R2 wide divisor");
    drain();
  endtask

  task automatic t_shr();
    send(2'd2, 5'd0, 3'd0, 32'd0, 32'hCAFEF00D, 32'hCAFEF00D, "R3 shift 0");
    send(2'd2, 5'd4, 3'd1, 32'h5, 32'hCAFEF00D, 32'h0CAFEF00, "R3 shift 4 xflags ignored");
    send(2'd2, 5'd31, 3'd7, 32'd0, 32'h80000000, 32'd1, "R3 shift 31");
    drain();
  endtask

  task automatic t_recip();
    logic [31:0] ix [4] = '{32'd0, 32'd6, 32'd1000003, 32'hFFFFFFFF};
    foreach (ix[i]) begin
      send(2'd3, 5'd2, 3'd1, 32'h92492492, ix[i], ix[i] / 32'd7, "R6 divide by 7");
      send(2'd3, 5'd1, 3'd1, 32'hAAAAAAAA, ix[i], ix[i] / 32'd3, "R6 divide by 3");
      send(2'd3, 5'd3, 3'd0, 32'd3123612579, ix[i], ix[i] / 32'd11, "R4 divide by 11");
    end
    drain();
  endtask

  task automatic t_implicit();
    send(2'd3, 5'd2, 3'd1, 32'h12492492, 32'hFFFFFFFF, 32'hFFFFFFFF / 32'd7, "R5 bit31 implied d7");
    send(2'd3, 5'd3, 3'd0, 32'h3A2E8BA3, 32'd987654321, 32'd987654321 / 32'd11, "R5 bit31 implied d11");
    sendm(2'd3, 5'd0, 3'd2, 32'h0, 32'h80000001, "R6 xflags 2 no correction");
    sendm(2'd3, 5'd0, 3'd0, 32'h0, 32'hFFFFFFFF, "R4 no preshift");
    drain();
  endtask

  task automatic t_latency();
    int cnt;
    in_valid = 1'b1; in_mode = 2'd0; in_index = 32'd4242;
    @(negedge clk);
    exp_q.push_back(32'd4242);
    tag_q.push_back("R7 data");
    @(posedge clk); #1;
    in_valid = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!out_valid && cnt < 10);
    chk(cnt == 3, "R7 latency", cnt, 3);
    drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 16; i++)
      sendm(2'(i % 4), 5'(i), 3'(i % 5), 32'h9E3779B9 * i, 32'h01234567 * (i + 1), "R10 stream");
    drain();
  endtask

  task automatic t_stall();
    out_ready = 1'b0;
    sendm(2'd1, 5'd2, 3'd2, 32'd0, 32'd777, "R8 item1");
    sendm(2'd2, 5'd3, 3'd0, 32'd0, 32'd777, "R8 item2");
    sendm(2'd3, 5'd2, 3'd1, 32'h92492492, 32'd777, "R8 item3");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      chk(out_index == exp_q[0], "R8 data held", out_index, exp_q[0]);
      chk(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    sendm(2'd0, 5'd0, 3'd0, 32'd0, 32'd31337, "R8 item4 same-cycle");
    drain();
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        @(posedge clk); #1;
        t_pass();
        t_modulo();
        t_shr();
        t_recip();
        t_implicit();
        t_latency();
        t_stream();
        t_stall();
      end
      begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule